// File: doc/BRIEF.md
# Debug Event Gate and Sticky Status

This block sits beside a small processor core and decides what happens to raw debug event pulses. It takes single-cycle hit pulses from four instruction-address comparators and two data-address comparators, qualifies them against the current debug modes, a per-resource enable mask and a per-resource ownership mask, and records each qualified hit in a sticky status register. Comparisons use effective addresses only; the comparators themselves are outside this block.

Two parties configure the block. Software sets the internal debug mode flag, programs the enables of the resources it owns, and clears status bits by writing ones. An external hardware debugger sets the external debug mode flag, decides per resource whether software or the debugger owns it, and may write any enable or status bit. A status bit on a software-owned resource raises a level interrupt request toward the core, gated by the core's debug-interrupt-enable input. A status bit on a debugger-owned resource raises a halt request instead. All pins are plain control and status signals: every event is a single-cycle pulse that is always accepted, so there is no valid/ready handshake and no back-pressure.

Top module: `dbg_event_gate`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears the status bits, both mode flags and all enables, and sets every ownership bit to 1 (software-owned); `irq_o` and `halt_o` are then low.
- R2: While both mode flags are clear, no status bit goes from 0 to 1, whatever the event inputs do.
- R3: With internal mode set, an event on a software-owned resource whose enable bit is 1 sets that resource's status bit at the next clock edge; with the enable bit 0 the event is dropped.
- R4: Status bits already set stay set when the mode flags are cleared.
- R5: A status bit is cleared only when a clear write carries a 1 in its position; a 0 leaves it unchanged. A clear and a qualified event on the same bit in the same cycle leave it set.
- R6: `irq_o` is high exactly while `irq_en_i` is high, internal mode is set, not every resource is debugger-owned, and at least one software-owned status bit is set; it is a level, not a pulse.
- R7: With internal mode clear, `irq_o` is low whatever the status register holds.
- R8: With external mode set and the ownership mask all zero, `irq_o` is low.
- R9: A resource is debugger-owned when external mode is set and its ownership bit is 0. Software enable writes and software clear writes have no effect on debugger-owned positions; debugger writes affect every position.
- R10: An enabled event on a debugger-owned resource is recorded whether or not internal mode is set, and `halt_o` is high while any debugger-owned status bit is set; `halt_o` is low while external mode is clear.
- R11: Every per-resource vector (status, enables, ownership, clear masks) uses bits 3..0 for instruction-address events 0..3 and bits 5..4 for data-address events 0..1.
- R12: When the debugger and software write the enables in the same cycle, the debugger's value is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_iac_i | input | 4 | Instruction-address hit pulses |
| evt_dac_i | input | 2 | Data-address hit pulses |
| irq_en_i | input | 1 | Core debug-interrupt enable |
| sw_ctl_we_i | input | 1 | Software write strobe for internal mode |
| sw_int_mode_i | input | 1 | Internal mode value written by software |
| sw_en_we_i | input | 1 | Software write strobe for enables |
| sw_en_i | input | 6 | Enable value written by software |
| sw_clr_we_i | input | 1 | Software status clear strobe |
| sw_clr_mask_i | input | 6 | Software clear mask, 1 clears |
| hw_we_i | input | 1 | Debugger write strobe for mode, ownership, enables |
| hw_ext_mode_i | input | 1 | External mode value from the debugger |
| hw_sw_own_i | input | 6 | Ownership value, 1 = software-owned |
| hw_en_i | input | 6 | Enable value written by the debugger |
| hw_clr_we_i | input | 1 | Debugger status clear strobe |
| hw_clr_mask_i | input | 6 | Debugger clear mask, 1 clears |
| status_o | output | 6 | Sticky status bits |
| en_o | output | 6 | Current enables |
| sw_own_o | output | 6 | Current ownership mask |
| int_mode_o | output | 1 | Internal mode flag |
| ext_mode_o | output | 1 | External mode flag |
| irq_o | output | 1 | Level debug interrupt request |
| halt_o | output | 1 | Halt request for debugger-owned hits |

## Verification
Two pairs of functions can land on the same edge: a write-one-to-clear and a fresh qualified event on the same status bit, and a software enable write arriving together with a debugger configuration write. Directed steps force each collision on a known bit and expect the bit to remain set and the debugger's enable value to win; the random phase then fires events, clears and both kinds of writes with independent probabilities so that these overlaps also occur under changing ownership, and every cycle compares status, enables, `irq_o` and `halt_o` against a bench model built from the requirements.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int unsigned DEF_N_IAC = 4;
  localparam int unsigned DEF_N_DAC = 2;

  typedef struct packed {
    logic ext_mode;
    logic int_mode;
  } mode_t;
endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
  import dbg_gate_pkg::*;
#(
  parameter int unsigned NRES = 6
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            sw_ctl_we_i,
  input  logic            sw_int_mode_i,
  input  logic            sw_en_we_i,
  input  logic [NRES-1:0] sw_en_i,
  input  logic            hw_we_i,
  input  logic            hw_ext_mode_i,
  input  logic [NRES-1:0] hw_sw_own_i,
  input  logic [NRES-1:0] hw_en_i,
  output mode_t           mode_o,
  output logic [NRES-1:0] own_o,
  output logic [NRES-1:0] en_o,
  output logic [NRES-1:0] hw_owned_o
);
  mode_t           mode_q;
  logic [NRES-1:0] own_q;
  logic [NRES-1:0] en_q;
  logic [NRES-1:0] hw_owned;

  // a position belongs to the debugger only while external mode holds
  assign hw_owned = mode_q.ext_mode ? ~own_q : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= '0;
      own_q  <= '1;
      en_q   <= '0;
    end else begin
      if (sw_ctl_we_i) mode_q.int_mode <= sw_int_mode_i;
      if (hw_we_i) begin
        mode_q.ext_mode <= hw_ext_mode_i;
        own_q           <= hw_sw_own_i;
        en_q            <= hw_en_i;
      end else if (sw_en_we_i) begin
        en_q <= (en_q & hw_owned) | (sw_en_i & ~hw_owned);
      end
    end
  end

  assign mode_o     = mode_q;
  assign own_o      = own_q;
  assign en_o       = en_q;
  assign hw_owned_o = hw_owned;
endmodule

// File: rtl/dbg_evt_qual.sv
module dbg_evt_qual #(
  parameter int unsigned NRES = 6
) (
  input  logic [NRES-1:0] evt_i,
  input  logic [NRES-1:0] en_i,
  input  logic [NRES-1:0] hw_owned_i,
  input  logic            int_mode_i,
  output logic [NRES-1:0] det_o
);
  for (genvar g = 0; g < NRES; g++) begin : g_res
    logic owner_live;
    // debugger-owned resources need no internal mode; others do
    assign owner_live = hw_owned_i[g] | int_mode_i;
    assign det_o[g]   = evt_i[g] & en_i[g] & owner_live;
  end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
  parameter int unsigned NRES = 6
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NRES-1:0] det_i,
  input  logic            sw_clr_we_i,
  input  logic [NRES-1:0] sw_clr_mask_i,
  input  logic            hw_clr_we_i,
  input  logic [NRES-1:0] hw_clr_mask_i,
  input  logic [NRES-1:0] hw_owned_i,
  output logic [NRES-1:0] status_o
);
  logic [NRES-1:0] stat_q;
  logic [NRES-1:0] sw_clr;
  logic [NRES-1:0] hw_clr;
  logic [NRES-1:0] clr;

  assign sw_clr = sw_clr_we_i ? (sw_clr_mask_i & ~hw_owned_i) : '0;
  assign hw_clr = hw_clr_we_i ? hw_clr_mask_i : '0;
  assign clr    = sw_clr | hw_clr;

  always_ff @(posedge clk_i) begin
    if (rst_i) stat_q <= '0;
    else       stat_q <= (stat_q & ~clr) | det_i;
  end

  assign status_o = stat_q;
endmodule

// File: rtl/dbg_event_gate.sv
module dbg_event_gate
  import dbg_gate_pkg::*;
#(
  parameter int unsigned N_IAC = DEF_N_IAC,
  parameter int unsigned N_DAC = DEF_N_DAC,
  localparam int unsigned NRES = N_IAC + N_DAC
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [N_IAC-1:0] evt_iac_i,
  input  logic [N_DAC-1:0] evt_dac_i,
  input  logic            irq_en_i,
  input  logic            sw_ctl_we_i,
  input  logic            sw_int_mode_i,
  input  logic            sw_en_we_i,
  input  logic [NRES-1:0] sw_en_i,
  input  logic            sw_clr_we_i,
  input  logic [NRES-1:0] sw_clr_mask_i,
  input  logic            hw_we_i,
  input  logic            hw_ext_mode_i,
  input  logic [NRES-1:0] hw_sw_own_i,
  input  logic [NRES-1:0] hw_en_i,
  input  logic            hw_clr_we_i,
  input  logic [NRES-1:0] hw_clr_mask_i,
  output logic [NRES-1:0] status_o,
  output logic [NRES-1:0] en_o,
  output logic [NRES-1:0] sw_own_o,
  output logic            int_mode_o,
  output logic            ext_mode_o,
  output logic            irq_o,
  output logic            halt_o
);
  mode_t           mode;
  logic [NRES-1:0] own;
  logic [NRES-1:0] en;
  logic [NRES-1:0] hw_owned;
  logic [NRES-1:0] det;
  logic [NRES-1:0] stat;
  logic [NRES-1:0] evt_all;
  logic            sw_any_owned;

  // instruction hits occupy the low positions, data hits above them
  assign evt_all = {evt_dac_i, evt_iac_i};

  dbg_cfg_regs #(.NRES(NRES)) u_cfg (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sw_ctl_we_i  (sw_ctl_we_i),
    .sw_int_mode_i(sw_int_mode_i),
    .sw_en_we_i   (sw_en_we_i),
    .sw_en_i      (sw_en_i),
    .hw_we_i      (hw_we_i),
    .hw_ext_mode_i(hw_ext_mode_i),
    .hw_sw_own_i  (hw_sw_own_i),
    .hw_en_i      (hw_en_i),
    .mode_o       (mode),
    .own_o        (own),
    .en_o         (en),
    .hw_owned_o   (hw_owned)
  );

  dbg_evt_qual #(.NRES(NRES)) u_qual (
    .evt_i     (evt_all),
    .en_i      (en),
    .hw_owned_i(hw_owned),
    .int_mode_i(mode.int_mode),
    .det_o     (det)
  );

  dbg_status_reg #(.NRES(NRES)) u_stat (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .det_i        (det),
    .sw_clr_we_i  (sw_clr_we_i),
    .sw_clr_mask_i(sw_clr_mask_i),
    .hw_clr_we_i  (hw_clr_we_i),
    .hw_clr_mask_i(hw_clr_mask_i),
    .hw_owned_i   (hw_owned),
    .status_o     (stat)
  );

  assign sw_any_owned = !(mode.ext_mode && (own == '0));

  assign irq_o  = irq_en_i && mode.int_mode && sw_any_owned &&
                  ((stat & ~hw_owned) != '0);
  assign halt_o = (stat & hw_owned) != '0;

  assign status_o   = stat;
  assign en_o       = en;
  assign sw_own_o   = own;
  assign int_mode_o = mode.int_mode;
  assign ext_mode_o = mode.ext_mode;
endmodule

// File: rtl/dbg_event_gate_chk.sv
module dbg_event_gate_chk #(
  parameter int unsigned N_IAC = 4,
  parameter int unsigned N_DAC = 2,
  localparam int unsigned NRES = N_IAC + N_DAC
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [N_IAC-1:0] evt_iac_i,
  input logic [N_DAC-1:0] evt_dac_i,
  input logic             irq_en_i,
  input logic             sw_en_we_i,
  input logic             sw_clr_we_i,
  input logic             hw_we_i,
  input logic             hw_clr_we_i,
  input logic [NRES-1:0]  hw_clr_mask_i,
  input logic [NRES-1:0]  status_o,
  input logic [NRES-1:0]  en_o,
  input logic [NRES-1:0]  sw_own_o,
  input logic             int_mode_o,
  input logic             ext_mode_o,
  input logic             irq_o,
  input logic             halt_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (status_o == '0 && en_o == '0 && sw_own_o == '1 &&
               !int_mode_o && !ext_mode_o && !irq_o && !halt_o));

  // R2
  no_new_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!int_mode_o && !ext_mode_o) |=> ((status_o & ~$past(status_o)) == '0));

  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sw_clr_we_i && !hw_clr_we_i) |=> (($past(status_o) & ~status_o) == '0));

  // R5
  clr_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hw_clr_we_i && int_mode_o && !ext_mode_o &&
     ((hw_clr_mask_i & {evt_dac_i, evt_iac_i} & en_o) != '0)) |=> (status_o != '0));

  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !irq_en_i |-> !irq_o);

  // R6
  irq_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_en_i && int_mode_o && !ext_mode_o && status_o != '0) |-> irq_o);

  // R7
  int_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !int_mode_o |-> !irq_o);

  // R8
  hw_all_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ext_mode_o && sw_own_o == '0) |-> !irq_o);

  // R9
  sw_en_blocked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ext_mode_o && sw_en_we_i && !hw_we_i) |=>
      ((en_o & ~$past(sw_own_o)) == ($past(en_o) & ~$past(sw_own_o))));

  // R10
  halt_ext_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    halt_o |-> ext_mode_o);
endmodule

bind dbg_event_gate dbg_event_gate_chk #(.N_IAC(N_IAC), .N_DAC(N_DAC)) u_chk (.*);

// File: tb/dbg_event_gate_bench.sv
module dbg_event_gate_bench;
  localparam int NI = 4;
  localparam int ND = 2;
  localparam int NR = NI + ND;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic [NI-1:0] evt_iac;
  logic [ND-1:0] evt_dac;
  logic          irq_en, sw_ctl_we, sw_int_mode, sw_en_we, sw_clr_we;
  logic          hw_we, hw_ext_mode, hw_clr_we;
  logic [NR-1:0] sw_en, sw_clr_mask, hw_sw_own, hw_en, hw_clr_mask;
  logic [NR-1:0] status, en, own;
  logic          int_mode, ext_mode, irq, halt;

  dbg_event_gate u_dbg_event_gate (
    .clk_i(clk), .rst_i(rst), .evt_iac_i(evt_iac), .evt_dac_i(evt_dac),
    .irq_en_i(irq_en), .sw_ctl_we_i(sw_ctl_we), .sw_int_mode_i(sw_int_mode),
    .sw_en_we_i(sw_en_we), .sw_en_i(sw_en), .sw_clr_we_i(sw_clr_we),
    .sw_clr_mask_i(sw_clr_mask), .hw_we_i(hw_we), .hw_ext_mode_i(hw_ext_mode),
    .hw_sw_own_i(hw_sw_own), .hw_en_i(hw_en), .hw_clr_we_i(hw_clr_we),
    .hw_clr_mask_i(hw_clr_mask), .status_o(status), .en_o(en), .sw_own_o(own),
    .int_mode_o(int_mode), .ext_mode_o(ext_mode), .irq_o(irq), .halt_o(halt)
  );

  // bench model
  logic [NR-1:0] m_stat, m_en, m_own;
  logic          m_int, m_ext;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] m_hw();
    return m_ext ? ~m_own : '0;
  endfunction

  function automatic logic m_irq();
    return irq_en && m_int && !(m_ext && m_own == '0) && ((m_stat & ~m_hw()) != '0);
  endfunction

  task automatic model_edge();
    logic [NR-1:0] hwo, det, clr;
    if (rst) begin
      m_stat = '0; m_en = '0; m_own = '1; m_int = 1'b0; m_ext = 1'b0;
      return;
    end
    hwo = m_hw();
    det = {evt_dac, evt_iac} & m_en & (hwo | {NR{m_int}});
    clr = (sw_clr_we ? (sw_clr_mask & ~hwo) : '0) | (hw_clr_we ? hw_clr_mask : '0);
    m_stat = (m_stat & ~clr) | det;
    if (hw_we) begin
      m_en = hw_en; m_own = hw_sw_own; m_ext = hw_ext_mode;
    end else if (sw_en_we) begin
      m_en = (m_en & hwo) | (sw_en & ~hwo);
    end
    if (sw_ctl_we) m_int = sw_int_mode;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(status == m_stat, "R5 status model", 32'(status), 32'(m_stat));
    chk(en == m_en, "R9 enable model", 32'(en), 32'(m_en));
    chk(own == m_own && ext_mode == m_ext && int_mode == m_int, "R12 config model",
        {own, ext_mode, int_mode}, {m_own, m_ext, m_int});
    chk(irq == m_irq(), "R6 irq model", 32'(irq), 32'(m_irq()));
    chk(halt == ((m_stat & m_hw()) != '0), "R10 halt model", 32'(halt),
        32'((m_stat & m_hw()) != '0));
    evt_iac = '0; evt_dac = '0; sw_ctl_we = 0; sw_en_we = 0; sw_clr_we = 0;
    hw_we = 0; hw_clr_we = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1; irq_en = 1; sw_int_mode = 0; hw_ext_mode = 0;
    sw_en = '0; sw_clr_mask = '0; hw_sw_own = '1; hw_en = '0; hw_clr_mask = '0;
    evt_iac = '0; evt_dac = '0; sw_ctl_we = 0; sw_en_we = 0; sw_clr_we = 0;
    hw_we = 0; hw_clr_we = 0;
    m_stat = 'x; m_en = 'x; m_own = 'x; m_int = 'x; m_ext = 'x;
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    chk(status == '0 && own == 6'h3F && en == '0 && !irq && !halt && !int_mode && !ext_mode,
        "R1 reset", {status, own}, {6'h00, 6'h3F});

    // R2: modes off
    sw_en_we = 1; sw_en = 6'h3F; step();
    evt_iac = 4'hF; evt_dac = 2'h3; step();
    chk(status == '0, "R2 no record", 32'(status), 0);

    // R3 / R11
    sw_ctl_we = 1; sw_int_mode = 1; step();
    evt_iac = 4'b0100; step();
    chk(status == 6'h04, "R3 R11 iac2", 32'(status), 32'h04);
    evt_dac = 2'b10; step();
    chk(status == 6'h24, "R11 dac1", 32'(status), 32'h24);
    sw_en_we = 1; sw_en = 6'h3E; step();
    evt_iac = 4'b0001; step();
    chk(status == 6'h24, "R3 disabled", 32'(status), 32'h24);

    // R6
    irq_en = 0; step();
    chk(!irq, "R6 gated", 32'(irq), 0);
    irq_en = 1; step();
    chk(irq, "R6 raised", 32'(irq), 1);
    step();
    chk(irq, "R6 level", 32'(irq), 1);

    // R7 / R4
    sw_ctl_we = 1; sw_int_mode = 0; step();
    chk(!irq, "R7 int off", 32'(irq), 0);
    chk(status == 6'h24, "R4 sticky", 32'(status), 32'h24);

    // R5
    sw_clr_we = 1; sw_clr_mask = '0; step();
    chk(status == 6'h24, "R5 zero mask", 32'(status), 32'h24);
    sw_clr_we = 1; sw_clr_mask = 6'h04; step();
    chk(status == 6'h20, "R5 clear", 32'(status), 32'h20);
    sw_ctl_we = 1; sw_int_mode = 1; step();
    evt_iac = 4'b0010; step();
    chk(status == 6'h22, "R5 setup", 32'(status), 32'h22);
    sw_clr_we = 1; sw_clr_mask = 6'h02; evt_iac = 4'b0010; step();
    chk(status == 6'h22, "R5 clear+event", 32'(status), 32'h22);

    // R8 / R10
    hw_we = 1; hw_ext_mode = 1; hw_sw_own = '0; hw_en = 6'h3F; step();
    chk(!irq, "R8 none sw-owned", 32'(irq), 0);
    chk(halt, "R10 halt", 32'(halt), 1);

    // R9
    sw_clr_we = 1; sw_clr_mask = 6'h3F; step();
    chk(status == 6'h22, "R9 sw clear ignored", 32'(status), 32'h22);
    sw_en_we = 1; sw_en = '0; step();
    chk(en == 6'h3F, "R9 sw enable ignored", 32'(en), 32'h3F);
    hw_clr_we = 1; hw_clr_mask = 6'h3F; step();
    chk(status == '0, "R9 hw clear", 32'(status), 0);

    // R10: hw-owned hit with internal mode off
    sw_ctl_we = 1; sw_int_mode = 0; step();
    evt_dac = 2'b01; step();
    chk(status == 6'h10 && halt && !irq, "R10 hw record", {status, halt, irq}, {6'h10, 2'b10});

    // mixed ownership
    hw_we = 1; hw_ext_mode = 1; hw_sw_own = 6'h0F; hw_en = 6'h3F; step();
    sw_clr_we = 1; sw_clr_mask = 6'h3F; step();
    chk(status == 6'h10, "R9 partial clear", 32'(status), 32'h10);
    evt_iac = 4'b0001; step();
    chk(status == 6'h10, "R3 int off sw-owned", 32'(status), 32'h10);
    sw_ctl_we = 1; sw_int_mode = 1; step();
    evt_iac = 4'b0001; step();
    chk(status == 6'h11 && irq && halt, "R6 mixed", {status, irq, halt}, {6'h11, 2'b11});

    // R12
    hw_we = 1; hw_ext_mode = 1; hw_sw_own = 6'h0F; hw_en = 6'h15;
    sw_en_we = 1; sw_en = 6'h3F; step();
    chk(en == 6'h15, "R12 debugger wins", 32'(en), 32'h15);

    hw_we = 1; hw_ext_mode = 0; hw_sw_own = '1; hw_en = 6'h3F;
    hw_clr_we = 1; hw_clr_mask = '1; step();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      evt_iac = NI'($urandom);
      evt_dac = ND'($urandom);
      irq_en = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) begin sw_ctl_we = 1; sw_int_mode = ($urandom % 3) != 0; end
      if ($urandom % 8 == 0) begin sw_en_we = 1; sw_en = NR'($urandom); end
      if ($urandom % 6 == 0) begin sw_clr_we = 1; sw_clr_mask = NR'($urandom); end
      if ($urandom % 16 == 0) begin
        hw_we = 1; hw_ext_mode = $urandom % 2; hw_sw_own = NR'($urandom);
        hw_en = NR'($urandom);
      end
      if ($urandom % 10 == 0) begin hw_clr_we = 1; hw_clr_mask = NR'($urandom); end
      step();
    end
    summary();
  end
endmodule